// File: doc/BRIEF.md
# Four-Error Sector Correction Applier

This block finishes the repair of one 512-byte sector after an external four-error locator has run. The sector sits in a local byte-wide RAM. When the locator signals completion, the block takes in the sector's stored parity bytes, the four syndrome words, the locator's state code, its error-count field and up to four packed (address, value) pairs. It then decides on one of three outcomes: skip the sector, report it as beyond repair, or patch the faulty bytes in the RAM by read-modify-write.

An erased sector is recognised because every one of its parity bytes reads 0xFF, and such a sector is left alone. The locator reports byte positions counted backwards from the end of the protected area. The block turns each position into a data index by subtracting it from 519. Any position that falls in the parity region, or beyond it, is dropped without being counted. When the work ends, the block pulses a completion strobe. At the same time it presents the number of bytes it rewrote and a flag that marks a sector that cannot be corrected.

Top module: `sector_fixup`

## Requirements
- R1: If all 10 bytes of `parityIn` equal 0xFF, the run ends with `fixCount` = 0 and `failFlag` = 0, and the RAM is not written. This holds whatever the state code is.
- R2: If every syndrome word in `syndIn` is zero (and R1 does not apply), the run ends with `fixCount` = 0, `failFlag` = 0 and no RAM access.
- R3: State code 0 (no error) ends the run with `fixCount` = 0, `failFlag` = 0 and no RAM access.
- R4: State code 1 (five or more errors) ends the run with `failFlag` = 1 and `fixCount` = 0, and the RAM is not written.
- R5: For state code 2 or 3, exactly `errCntField`+1 entries (1 to 4) are processed, in entry order 0, 1, 2, 3.
- R6: Entry i is taken from 32-bit word i/2 of `addrWords` and of `valWords` (word 0 in bits 31:0). Within that word it uses the half at bit offset 16*(i mod 2). The address is bits 9:0 of that half and the value is bits 7:0. The remaining bits of each half are ignored.
- R7: An entry with address A, where 8 <= A <= 519, XORs its value into RAM byte 519-A and counts as one correction. Any other address is skipped and not counted. Two entries that hit the same byte both take effect.
- R8: Each correction is one cycle with `ramRe` high, followed by one cycle with `ramWe` high at the same address, with `ramWdata` = read data XOR value. Counting from the clock edge that samples `locDone`, `done` appears after 2 cycles on a skip path. On a correcting path it appears after 3 cycles, plus 3 per applied entry and 1 per skipped entry.
- R9: `done` is high for exactly one cycle and only after `locDone` has been sampled. `fixCount` and `failFlag` are valid with `done` and hold until the next run.
- R10: During and after reset, `done`, `ramRe`, `ramWe`, `failFlag` and `fixCount` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| locDone | input | 1 | Locator finished; all result inputs valid this cycle |
| parityIn | input | 80 | Stored parity bytes, byte k in bits 8k+7:8k |
| syndIn | input | 40 | Four 10-bit syndrome words |
| corrState | input | 2 | Locator state code (0 none, 1 too many, 2/3 complete) |
| errCntField | input | 2 | Number of errors minus one |
| addrWords | input | 64 | Two words of packed 10-bit error addresses |
| valWords | input | 64 | Two words of packed 8-bit error values |
| ramAddr | output | 9 | Sector RAM byte address |
| ramRe | output | 1 | Sector RAM read strobe (data one cycle later) |
| ramRdata | input | 8 | Sector RAM read data |
| ramWe | output | 1 | Sector RAM write strobe |
| ramWdata | output | 8 | Sector RAM write data |
| done | output | 1 | One-cycle completion pulse |
| fixCount | output | 3 | Bytes corrected in the last run |
| failFlag | output | 1 | Last sector was uncorrectable |

## Verification
A stuck or wrong sequencer state shows up within a few cycles of `locDone`. It appears either as a completion pulse that comes too early or too late against the cycle count in R8, or as a read or write strobe on a path that must not touch the RAM. A wrong entry index or address mapping shows up only in the sector contents, so the whole 512-byte RAM is compared with an independent model after every run. Counter faults appear in `fixCount` and in the number of write strobes seen during the run.

// File: rtl/sector_fixup_pkg.sv
package sector_fixup_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECIDE,
    ST_CHECK,
    ST_READ,
    ST_WRITE,
    ST_FINISH
  } fixState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch locator results, clear run state
    logic setFail;   // mark sector uncorrectable
    logic advance;   // move to next entry
    logic bumpCnt;   // one more byte corrected
  } fixCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic       erased;
    logic       syndZero;
    logic [1:0] stateCode;
    logic       moreLeft;
    logic       inRange;
  } fixStat_t;

endpackage

// File: rtl/sector_fixup_dp.sv
module sector_fixup_dp
  import sector_fixup_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int PARITY_BYTES = 10,
  parameter int SYND_N       = 4,
  parameter int SYND_W       = 10,
  parameter int MAX_ERR      = 4,
  parameter int ENTRY_ADDR_W = 10,
  parameter int ENTRY_VAL_W  = 8,
  parameter int ADDR_BIAS    = 7,
  localparam int RAM_AW = $clog2(SECTOR_BYTES),
  localparam int CNT_W  = $clog2(MAX_ERR),
  localparam int IDX_W  = $clog2(MAX_ERR + 1),
  localparam int WORD_N = (MAX_ERR + 1) / 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  fixCtl_t                    ctl,
  output fixStat_t                   stat,
  input  logic [PARITY_BYTES*8-1:0]  parityIn,
  input  logic [SYND_N*SYND_W-1:0]   syndIn,
  input  logic [1:0]                 corrState,
  input  logic [CNT_W-1:0]           errCntField,
  input  logic [WORD_N*32-1:0]       addrWords,
  input  logic [WORD_N*32-1:0]       valWords,
  input  logic                       ramWrite,
  output logic [RAM_AW-1:0]          ramAddr,
  input  logic [ENTRY_VAL_W-1:0]     ramRdata,
  output logic [ENTRY_VAL_W-1:0]     ramWdata,
  output logic [IDX_W-1:0]           fixCount,
  output logic                       failFlag
);

  localparam int SEL_W  = (MAX_ERR > 1) ? $clog2(MAX_ERR) : 1;
  localparam int TOP_I  = SECTOR_BYTES + ADDR_BIAS;
  localparam logic [ENTRY_ADDR_W:0] TOP_V = (ENTRY_ADDR_W + 1)'(TOP_I);
  localparam logic [ENTRY_ADDR_W:0] LOW_V = (ENTRY_ADDR_W + 1)'(ADDR_BIAS + 1);

  logic [MAX_ERR-1:0][ENTRY_ADDR_W-1:0] entAddr, entAddrQ;
  logic [MAX_ERR-1:0][ENTRY_VAL_W-1:0]  entVal, entValQ;
  logic [MAX_ERR-1:0][15-ENTRY_ADDR_W:0] padA;
  logic [MAX_ERR-1:0][15-ENTRY_VAL_W:0]  padV;

  // unpack entries: word i/2, half i%2
  for (genvar i = 0; i < MAX_ERR; i++) begin : gEntry
    localparam int WORD = i / 2;
    localparam int OFS  = 32 * WORD + 16 * (i % 2);
    assign entAddr[i] = addrWords[OFS +: ENTRY_ADDR_W];
    assign entVal[i]  = valWords[OFS +: ENTRY_VAL_W];
    assign padA[i]    = addrWords[OFS + ENTRY_ADDR_W +: 16 - ENTRY_ADDR_W];
    assign padV[i]    = valWords[OFS + ENTRY_VAL_W +: 16 - ENTRY_VAL_W];
  end

  logic unusedBits;
  assign unusedBits = ^{padA, padV};

  logic             erasedQ, syndZeroQ;
  logic [1:0]       stateQ;
  logic [CNT_W-1:0] cntQ;
  logic [IDX_W-1:0] idxQ, fixCntQ;
  logic             failQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      erasedQ   <= 1'b0;
      syndZeroQ <= 1'b0;
      stateQ    <= '0;
      cntQ      <= '0;
      entAddrQ  <= '0;
      entValQ   <= '0;
      idxQ      <= '0;
      fixCntQ   <= '0;
      failQ     <= 1'b0;
    end else if (ctl.capture) begin
      erasedQ   <= &parityIn;
      syndZeroQ <= ~|syndIn;
      stateQ    <= corrState;
      cntQ      <= errCntField;
      entAddrQ  <= entAddr;
      entValQ   <= entVal;
      idxQ      <= '0;
      fixCntQ   <= '0;
      failQ     <= 1'b0;
    end else begin
      if (ctl.setFail) failQ   <= 1'b1;
      if (ctl.advance) idxQ    <= idxQ + IDX_W'(1);
      if (ctl.bumpCnt) fixCntQ <= fixCntQ + IDX_W'(1);
    end
  end

  logic [SEL_W-1:0]        sel;
  logic [ENTRY_ADDR_W:0]   selAddr;
  logic [ENTRY_VAL_W-1:0]  selVal;
  logic [IDX_W-1:0]        numErr;

  assign sel     = idxQ[SEL_W-1:0];
  assign selAddr = {1'b0, entAddrQ[sel]};
  assign selVal  = entValQ[sel];
  assign numErr  = IDX_W'(cntQ) + IDX_W'(1);

  assign stat.erased    = erasedQ;
  assign stat.syndZero  = syndZeroQ;
  assign stat.stateCode = stateQ;
  assign stat.moreLeft  = idxQ < numErr;
  assign stat.inRange   = (selAddr >= LOW_V) && (selAddr <= TOP_V);

  assign ramAddr  = RAM_AW'(TOP_V - selAddr);
  assign ramWdata = ramWrite ? (ramRdata ^ selVal) : '0;
  assign fixCount = fixCntQ;
  assign failFlag = failQ;

endmodule

// File: rtl/sector_fixup_ctrl.sv
module sector_fixup_ctrl
  import sector_fixup_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     locDone,
  input  fixStat_t stat,
  output fixCtl_t  ctl,
  output logic     ramRead,
  output logic     ramWrite,
  output logic     done
);

  fixState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    unique case (state)
      ST_IDLE: begin
        if (locDone) begin
          ctl.capture = 1'b1;
          nextState   = ST_DECIDE;
        end
      end
      ST_DECIDE: begin
        if (stat.erased || stat.syndZero || stat.stateCode == 2'd0) begin
          nextState = ST_FINISH;
        end else if (stat.stateCode == 2'd1) begin
          ctl.setFail = 1'b1;
          nextState   = ST_FINISH;
        end else begin
          nextState = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (!stat.moreLeft)     nextState = ST_FINISH;
        else if (stat.inRange)  nextState = ST_READ;
        else                    ctl.advance = 1'b1;
      end
      ST_READ:  nextState = ST_WRITE;
      ST_WRITE: begin
        ctl.advance = 1'b1;
        ctl.bumpCnt = 1'b1;
        nextState   = ST_CHECK;
      end
      ST_FINISH: nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  assign ramRead  = (state == ST_READ);
  assign ramWrite = (state == ST_WRITE);
  assign done     = (state == ST_FINISH);

endmodule

// File: rtl/sector_fixup.sv
module sector_fixup
  import sector_fixup_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int PARITY_BYTES = 10,
  parameter int SYND_N       = 4,
  parameter int SYND_W       = 10,
  parameter int MAX_ERR      = 4,
  parameter int ENTRY_ADDR_W = 10,
  parameter int ENTRY_VAL_W  = 8,
  parameter int ADDR_BIAS    = 7,
  localparam int RAM_AW = $clog2(SECTOR_BYTES),
  localparam int CNT_W  = $clog2(MAX_ERR),
  localparam int IDX_W  = $clog2(MAX_ERR + 1),
  localparam int WORD_N = (MAX_ERR + 1) / 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      locDone,
  input  logic [PARITY_BYTES*8-1:0] parityIn,
  input  logic [SYND_N*SYND_W-1:0]  syndIn,
  input  logic [1:0]                corrState,
  input  logic [CNT_W-1:0]          errCntField,
  input  logic [WORD_N*32-1:0]      addrWords,
  input  logic [WORD_N*32-1:0]      valWords,
  output logic [RAM_AW-1:0]         ramAddr,
  output logic                      ramRe,
  input  logic [ENTRY_VAL_W-1:0]    ramRdata,
  output logic                      ramWe,
  output logic [ENTRY_VAL_W-1:0]    ramWdata,
  output logic                      done,
  output logic [IDX_W-1:0]          fixCount,
  output logic                      failFlag
);

  fixCtl_t  ctl;
  fixStat_t stat;

  sector_fixup_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .locDone  (locDone),
    .stat     (stat),
    .ctl      (ctl),
    .ramRead  (ramRe),
    .ramWrite (ramWe),
    .done     (done)
  );

  sector_fixup_dp #(
    .SECTOR_BYTES (SECTOR_BYTES),
    .PARITY_BYTES (PARITY_BYTES),
    .SYND_N       (SYND_N),
    .SYND_W       (SYND_W),
    .MAX_ERR      (MAX_ERR),
    .ENTRY_ADDR_W (ENTRY_ADDR_W),
    .ENTRY_VAL_W  (ENTRY_VAL_W),
    .ADDR_BIAS    (ADDR_BIAS)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .stat        (stat),
    .parityIn    (parityIn),
    .syndIn      (syndIn),
    .corrState   (corrState),
    .errCntField (errCntField),
    .addrWords   (addrWords),
    .valWords    (valWords),
    .ramWrite    (ramWe),
    .ramAddr     (ramAddr),
    .ramRdata    (ramRdata),
    .ramWdata    (ramWdata),
    .fixCount    (fixCount),
    .failFlag    (failFlag)
  );

endmodule

// File: rtl/sector_fixup_chk.sv
module sector_fixup_chk #(
  parameter int RAM_AW  = 9,
  parameter int IDX_W   = 3,
  parameter int MAX_ERR = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              done,
  input logic              ramRe,
  input logic              ramWe,
  input logic [RAM_AW-1:0] ramAddr,
  input logic [IDX_W-1:0]  fixCount,
  input logic              failFlag
);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_read_then_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    ramRe |=> ramWe && ramAddr == $past(ramAddr));

  assert_write_follows_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> $past(ramRe));

  assert_no_write_on_fail_R4: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> !failFlag);

  assert_fail_zero_count_R4: assert property (@(posedge clk) disable iff (!rstN)
    (done && failFlag) |-> fixCount == '0);

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    fixCount <= IDX_W'(MAX_ERR));

  assert_ram_quiet_on_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !ramRe && !ramWe);

endmodule

bind sector_fixup sector_fixup_chk #(
  .RAM_AW  (RAM_AW),
  .IDX_W   (IDX_W),
  .MAX_ERR (MAX_ERR)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .done     (done),
  .ramRe    (ramRe),
  .ramWe    (ramWe),
  .ramAddr  (ramAddr),
  .fixCount (fixCount),
  .failFlag (failFlag)
);

// File: tb/sector_fixup_tb.sv
module sector_fixup_tb;

  typedef struct packed {
    logic        ff;
    logic [39:0] synd;
    logic [1:0]  st;
    logic [1:0]  cnt;
    logic [63:0] a;
    logic [63:0] v;
    logic [2:0]  expCnt;
    logic        expFail;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    // R1 erased, state 1 still no fail
    '{1'b1, 40'h1, 2'd1, 2'd3, {32'h01F4_012C, 32'h0064_0008}, 64'h1, 3'd0, 1'b0},
    // R2 zero syndromes
    '{1'b0, 40'h0, 2'd2, 2'd0, {32'h0, 32'h0000_0207}, 64'h5, 3'd0, 1'b0},
    // R3 state 0
    '{1'b0, 40'h2, 2'd0, 2'd0, {32'h0, 32'h0000_0207}, 64'h5, 3'd0, 1'b0},
    // R4 state 1
    '{1'b0, 40'h4, 2'd1, 2'd3, {32'h01F4_012C, 32'h0064_0008}, 64'hFF, 3'd0, 1'b1},
    // R5 single error at byte 0
    '{1'b0, 40'h8, 2'd2, 2'd0, {32'h0, 32'h0000_0207}, {32'h0, 32'h0000_005A}, 3'd1, 1'b0},
    // R5 R6 four errors
    '{1'b0, 40'h10, 2'd3, 2'd3, {32'h01F4_012C, 32'h0064_0008},
      {32'h003C_00FF, 32'h0080_0001}, 3'd4, 1'b0},
    // R7 address 7 dropped
    '{1'b0, 40'h20, 2'd2, 2'd1, {32'h0, 32'h0009_0007}, {32'h0, 32'h0011_0022}, 3'd1, 1'b0},
    // R7 address 600 dropped, same byte twice
    '{1'b0, 40'h40, 2'd3, 2'd2, {32'h03FF_00C8, 32'h00C8_0258},
      {32'h0099_000F, 32'h0033_0044}, 3'd2, 1'b0},
    // R5 only two of four applied
    '{1'b0, 40'h80, 2'd2, 2'd1, {32'h003C_0046, 32'h0190_0032},
      {32'h0009_0008, 32'h0007_0006}, 3'd2, 1'b0},
    // R1 erased with valid entries
    '{1'b1, 40'h100, 2'd2, 2'd0, {32'h0, 32'h0000_0207}, {32'h0, 32'h0000_0077}, 3'd0, 1'b0},
    // R6 junk in upper half bits; top syndrome bit only
    '{1'b0, 40'h80_0000_0000, 2'd2, 2'd0, {32'h0, 32'h0000_FE07}, {32'h0, 32'h0000_FF01}, 3'd1, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        locDone = 1'b0;
  logic [79:0] parityIn = '0;
  logic [39:0] syndIn = '0;
  logic [1:0]  corrState = '0;
  logic [1:0]  errCntField = '0;
  logic [63:0] addrWords = '0;
  logic [63:0] valWords = '0;
  logic [8:0]  ramAddr;
  logic        ramRe, ramWe;
  logic [7:0]  ramRdata, ramWdata;
  logic        done;
  logic [2:0]  fixCount;
  logic        failFlag;
  logic        fillMem = 1'b0;

  logic [7:0] mem    [512];
  logic [7:0] expMem [512];
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  sector_fixup u_dut (
    .clk(clk), .rstN(rstN), .locDone(locDone), .parityIn(parityIn),
    .syndIn(syndIn), .corrState(corrState), .errCntField(errCntField),
    .addrWords(addrWords), .valWords(valWords), .ramAddr(ramAddr),
    .ramRe(ramRe), .ramRdata(ramRdata), .ramWe(ramWe), .ramWdata(ramWdata),
    .done(done), .fixCount(fixCount), .failFlag(failFlag)
  );

  // sector RAM model, one-cycle read latency
  always_ff @(posedge clk) begin
    if (fillMem) begin
      for (int k = 0; k < 512; k++) mem[k] <= 8'((k * 7 + 3) & 255);
    end else begin
      if (ramRe) ramRdata <= mem[ramAddr];
      if (ramWe) mem[ramAddr] <= ramWdata;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  // independent model of R5..R8
  task automatic model(input vec_t vv, output int lat, output int nfix);
    lat = 2;
    nfix = 0;
    if (!vv.ff && vv.synd != 0 && vv.st >= 2) begin
      lat = 3;
      for (int i = 0; i <= int'(vv.cnt); i++) begin
        logic [31:0] aw, vw;
        logic [9:0]  ad;
        logic [7:0]  vl;
        aw = vv.a[32*(i/2) +: 32];
        vw = vv.v[32*(i/2) +: 32];
        ad = aw[16*(i%2) +: 10];
        vl = vw[16*(i%2) +: 8];
        if (ad >= 10'd8 && ad <= 10'd519) begin
          expMem[519 - int'(ad)] ^= vl;
          nfix++;
          lat += 3;
        end else begin
          lat += 1;
        end
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk("R9", "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    for (int k = 0; k < 512; k++) expMem[k] = 8'((k * 7 + 3) & 255);
    fillMem = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "done in reset", int'(done), 0);
    chk("R10", "ramRe in reset", int'(ramRe), 0);
    chk("R10", "ramWe in reset", int'(ramWe), 0);
    fillMem = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    chk("R10", "fixCount after reset", int'(fixCount), 0);
    chk("R10", "failFlag after reset", int'(failFlag), 0);
    begin
      int seen = 0;
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        if (done || ramRe || ramWe) seen++;
      end
      chk("R9", "activity without locDone", seen, 0);
    end

    for (int n = 0; n < NV; n++) begin
      vec_t vv;
      int expLat, expFix, lat, writes, mism;
      vv = VECS[n];
      model(vv, expLat, expFix);
      parityIn    = vv.ff ? {10{8'hFF}} : {{9{8'hFF}}, 8'hFE};
      syndIn      = vv.synd;
      corrState   = vv.st;
      errCntField = vv.cnt;
      addrWords   = vv.a;
      valWords    = vv.v;
      locDone     = 1'b1;
      lat = 0;
      writes = 0;
      @(negedge clk);
      locDone = 1'b0;
      parityIn = '0;
      addrWords = '1;
      lat = 1;
      while (!done && lat < 200) begin
        if (ramWe) writes++;
        @(negedge clk);
        lat++;
      end
      chk("R8", $sformatf("vec%0d latency", n), lat, expLat);
      chk("R5", $sformatf("vec%0d fixCount", n), int'(fixCount), int'(vv.expCnt));
      chk("R4", $sformatf("vec%0d failFlag", n), int'(failFlag), int'(vv.expFail));
      chk("R7", $sformatf("vec%0d model count", n), expFix, int'(vv.expCnt));
      chk("R8", $sformatf("vec%0d write strobes", n), writes, int'(vv.expCnt));
      @(negedge clk);
      chk("R9", $sformatf("vec%0d done width", n), int'(done), 0);
      chk("R9", $sformatf("vec%0d fixCount held", n), int'(fixCount), int'(vv.expCnt));
      mism = 0;
      for (int k = 0; k < 512; k++) if (mem[k] !== expMem[k]) mism++;
      chk("R6", $sformatf("vec%0d sector bytes mismatched", n), mism, 0);
      repeat (2) @(negedge clk);
    end

    summary();
    $finish;
  end

endmodule